// File: doc/BRIEF.md
# Sigma-Delta ADC Result Correction Pipeline

This block takes the signed results of a sigma-delta decimation filter and turns them into corrected 16-bit output codes. Each result arrives with a one-cycle valid strobe. If chop mode is on, the block pairs consecutive results and keeps their mean. It then removes a programmable zero-scale offset and applies a programmable gain. The scaled value is rounded to the output width, limited to the output range, and presented either as a signed code or as a code biased by half scale.

The steps always run in the same order. The offset is removed before the gain is applied, so an offset measured at zero input stays valid whatever the gain setting. The offset, gain and format inputs are sampled together with the result that completes a sample: in chop mode this is the second result of the pair. A sample therefore keeps the settings it was taken with, even if the inputs change while it is still in the pipeline. The pipeline has three register stages. It accepts a new result on every clock.

Top module: `adc_cal_path`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `out_code` is 0x0000.
- R2: With chop mode off, every input strobe produces exactly one `out_valid` pulse 3 clocks later. Strobes on consecutive cycles produce outputs on consecutive cycles.
- R3: With chop mode on, strobes are grouped in pairs. The first strobe of a pair only stores its result. The second produces one output from floor((a+b)/2), 3 clocks after that second strobe. Whenever `chop_en` is low, the pairing restarts, so the next strobe taken in chop mode is the first of a new pair.
- R4: The offset is subtracted before any scaling: the value fed to the gain is (filter result or chop mean) minus `offset`, with both taken as 24-bit signed.
- R5: The gain is unsigned with 1 integer bit and 15 fraction bits, so 0x8000 is unity. With unity gain and zero offset, the output is the top 16 bits of the 24-bit input after rounding.
- R6: The corrected value v = (x − offset)·gain is reduced to 16 bits by discarding 23 bits with round-half-up, which gives floor((v + 2^22) / 2^23).
- R7: A rounded value above 32767 gives 0x7FFF. A rounded value below −32768 gives 0x8000 in signed format. Nothing wraps.
- R8: With `fmt_offset_bin` = 1, the output is the limited signed code with its MSB inverted. With 0, the output is the signed code itself.
- R9: `offset`, `gain` and `fmt_offset_bin` are taken in the cycle of the strobe that completes a sample. Changing them afterwards does not affect that sample's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Filter result strobe |
| in_data | input | 24 | Filter result, signed |
| chop_en | input | 1 | Pair and average consecutive results |
| offset | input | 24 | Offset coefficient, signed |
| gain | input | 16 | Gain coefficient, unsigned, 0x8000 is unity |
| fmt_offset_bin | input | 1 | 1 selects offset-binary output, 0 selects twos complement |
| out_valid | output | 1 | Corrected code strobe |
| out_code | output | 16 | Corrected output code |

## Verification
The assertions check on every cycle that the result pipeline stays in step:
- With chop mode off, a strobe reaches the output three clocks later.
- With chop mode on, the pipeline never emits two chop results on adjacent cycles.
- Zero gain gives a zero product.
- A rounded value out of range on either side leaves the output at the matching full-scale code.

The arithmetic itself can only be shown by the bench scenarios. These compare each output against a behavioural model and cover:
- rounding exactly at the half-LSB points;
- offset subtraction ahead of the gain;
- chop pairs, including pairing that restarts mid-pair;
- the offset-binary mapping;
- coefficients that change while earlier samples are still in the pipeline.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
   typedef enum logic {
      FMT_TWOS   = 1'b0,
      FMT_OFSBIN = 1'b1
   } code_fmt_e;

   localparam int DEF_IN_W   = 24;
   localparam int DEF_GAIN_W = 16;
   localparam int DEF_FRAC_W = 15;
   localparam int DEF_OUT_W  = 16;
endpackage

// File: rtl/adc_cal_chop_ofs.sv
module adc_cal_chop_ofs #(
   parameter int IN_W         = 24,
   parameter int SIDE_W       = 17,
   parameter bit CHOP_SUPPORT = 1'b1,
   localparam int D_W         = IN_W + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [IN_W-1:0]       in_data,
   input  logic                  chop_en,
   input  logic [IN_W-1:0]       offset,
   input  logic [SIDE_W-1:0]     side_in,
   output logic                  s_valid,
   output logic                  s_chop,
   output logic signed [D_W-1:0] s_diff,
   output logic [SIDE_W-1:0]     side_out
);
   logic                   take_now;
   logic                   chop_take;
   logic signed [IN_W:0]   sel_val;

   generate
      if (IN_W < 8) begin : g_bad_width
         $error("adc_cal_chop_ofs: IN_W too small");
      end
   endgenerate

   generate
      if (CHOP_SUPPORT) begin : g_chop
         logic                 phase_q;
         logic [IN_W-1:0]      held_q;
         logic signed [IN_W:0] pair_sum;
         logic signed [IN_W:0] pair_avg;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               phase_q <= 1'b0;
               held_q  <= '0;
            end else if (!chop_en) begin
               phase_q <= 1'b0;
            end else if (in_valid) begin
               phase_q <= ~phase_q;
               if (!phase_q) held_q <= in_data;
            end
         end

         always_comb begin
            pair_sum  = $signed({held_q[IN_W-1], held_q}) + $signed({in_data[IN_W-1], in_data});
            pair_avg  = pair_sum >>> 1;
            take_now  = in_valid && (!chop_en || phase_q);
            chop_take = take_now && chop_en;
            sel_val   = chop_en ? pair_avg : $signed({in_data[IN_W-1], in_data});
         end
      end else begin : g_nochop
         always_comb begin
            take_now  = in_valid;
            chop_take = 1'b0;
            sel_val   = $signed({in_data[IN_W-1], in_data});
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_valid  <= 1'b0;
         s_chop   <= 1'b0;
         s_diff   <= '0;
         side_out <= '0;
      end else begin
         s_valid <= take_now;
         s_chop  <= chop_take;
         if (take_now) begin
            s_diff   <= $signed({sel_val[IN_W], sel_val}) - $signed({{2{offset[IN_W-1]}}, offset});
            side_out <= side_in;
         end
      end
   end

   // R3: a chop result needs two strobes, so chop results never land on adjacent cycles
   assert_chop_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_chop) |=> !(s_valid && s_chop));
endmodule

// File: rtl/adc_cal_gain.sv
module adc_cal_gain #(
   parameter int D_W    = 26,
   parameter int G_W    = 16,
   localparam int P_W   = D_W + G_W + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  d_valid,
   input  logic signed [D_W-1:0] d_diff,
   input  logic [G_W-1:0]        d_gain,
   input  logic                  d_fmt,
   output logic                  p_valid,
   output logic signed [P_W-1:0] p_prod,
   output logic                  p_fmt
);
   logic signed [P_W-1:0] prod_c;

   generate
      if (G_W < 2) begin : g_bad_gain
         $error("adc_cal_gain: G_W too small");
      end
   endgenerate

   always_comb prod_c = d_diff * $signed({1'b0, d_gain});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_valid <= 1'b0;
         p_prod  <= '0;
         p_fmt   <= 1'b0;
      end else begin
         p_valid <= d_valid;
         if (d_valid) begin
            p_prod <= prod_c;
            p_fmt  <= d_fmt;
         end
      end
   end

   // R5: a zero gain coefficient must give a zero product
   assert_zero_gain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && d_gain == '0) |=> (p_prod == '0));
endmodule

// File: rtl/adc_cal_fmt.sv
module adc_cal_fmt #(
   parameter int P_W   = 43,
   parameter int SHIFT = 23,
   parameter int OUT_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  p_valid,
   input  logic signed [P_W-1:0] p_prod,
   input  logic                  p_fmt,
   output logic                  out_valid,
   output logic [OUT_W-1:0]      out_code
);
   import adc_cal_pkg::*;

   localparam logic signed [P_W:0] HALF = {{(P_W-SHIFT+1){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
   localparam logic signed [P_W:0] MAXV = {{(P_W-OUT_W+2){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [P_W:0] MINV = {{(P_W-OUT_W+2){1'b1}}, {(OUT_W-1){1'b0}}};

   logic signed [P_W:0]  rnd;
   logic                 over_hi;
   logic                 over_lo;
   logic [OUT_W-1:0]     clamped;
   logic [OUT_W-1:0]     coded;

   generate
      if (SHIFT < 1 || SHIFT + OUT_W > P_W) begin : g_bad_shift
         $error("adc_cal_fmt: SHIFT out of range");
      end
   endgenerate

   always_comb begin
      rnd     = ($signed({p_prod[P_W-1], p_prod}) + HALF) >>> SHIFT;
      over_hi = rnd > MAXV;
      over_lo = rnd < MINV;
      if (over_hi)      clamped = MAXV[OUT_W-1:0];
      else if (over_lo) clamped = MINV[OUT_W-1:0];
      else              clamped = rnd[OUT_W-1:0];
      if (code_fmt_e'(p_fmt) == FMT_OFSBIN) coded = {~clamped[OUT_W-1], clamped[OUT_W-2:0]};
      else                                   coded = clamped;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= '0;
      end else begin
         out_valid <= p_valid;
         if (p_valid) out_code <= coded;
      end
   end

   // R7: positive overflow lands on positive full scale (either format)
   assert_sat_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid && over_hi) |=> (out_code[OUT_W-2:0] == {(OUT_W-1){1'b1}}
                                && out_code[OUT_W-1] == $past(p_fmt)));
   // R7: negative overflow lands on negative full scale (either format)
   assert_sat_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid && over_lo) |=> (out_code[OUT_W-2:0] == '0
                                && out_code[OUT_W-1] == !$past(p_fmt)));
endmodule

// File: rtl/adc_cal_path.sv
module adc_cal_path #(
   parameter int IN_W         = adc_cal_pkg::DEF_IN_W,
   parameter int GAIN_W       = adc_cal_pkg::DEF_GAIN_W,
   parameter int FRAC_W       = adc_cal_pkg::DEF_FRAC_W,
   parameter int OUT_W        = adc_cal_pkg::DEF_OUT_W,
   parameter bit CHOP_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_data,
   input  logic              chop_en,
   input  logic [IN_W-1:0]   offset,
   input  logic [GAIN_W-1:0] gain,
   input  logic              fmt_offset_bin,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_code
);
   localparam int D_W    = IN_W + 2;
   localparam int P_W    = D_W + GAIN_W + 1;
   localparam int SHIFT  = FRAC_W + IN_W - OUT_W;
   localparam int SIDE_W = GAIN_W + 1;

   generate
      if (OUT_W < 2 || OUT_W > IN_W) begin : g_bad_out
         $error("adc_cal_path: OUT_W must lie in 2..IN_W");
      end
      if (FRAC_W >= GAIN_W) begin : g_bad_frac
         $error("adc_cal_path: FRAC_W must be below GAIN_W");
      end
   endgenerate

   logic                  s_valid;
   logic                  s_chop;
   logic signed [D_W-1:0] s_diff;
   logic [SIDE_W-1:0]     s_side;
   logic                  p_valid;
   logic signed [P_W-1:0] p_prod;
   logic                  p_fmt;

   adc_cal_chop_ofs #(
      .IN_W(IN_W), .SIDE_W(SIDE_W), .CHOP_SUPPORT(CHOP_SUPPORT)
   ) u_stage1 (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .chop_en(chop_en), .offset(offset),
      .side_in({fmt_offset_bin, gain}),
      .s_valid(s_valid), .s_chop(s_chop), .s_diff(s_diff), .side_out(s_side)
   );

   adc_cal_gain #(.D_W(D_W), .G_W(GAIN_W)) u_stage2 (
      .clk(clk), .rst_n(rst_n),
      .d_valid(s_valid), .d_diff(s_diff),
      .d_gain(s_side[GAIN_W-1:0]), .d_fmt(s_side[GAIN_W]),
      .p_valid(p_valid), .p_prod(p_prod), .p_fmt(p_fmt)
   );

   adc_cal_fmt #(.P_W(P_W), .SHIFT(SHIFT), .OUT_W(OUT_W)) u_stage3 (
      .clk(clk), .rst_n(rst_n),
      .p_valid(p_valid), .p_prod(p_prod), .p_fmt(p_fmt),
      .out_valid(out_valid), .out_code(out_code)
   );

   // R2: with chop off, a strobe reaches the output exactly three clocks later
   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !chop_en) |-> ##3 out_valid);
endmodule

// File: tb/sim_adc_cal_path.sv
module sim_adc_cal_path;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [23:0] in_data = '0;
   logic        chop_en = 1'b0;
   logic [23:0] offset = '0;
   logic [15:0] gain = 16'h8000;
   logic        fmt_offset_bin = 1'b0;
   logic        out_valid;
   logic [15:0] out_code;

   adc_cal_path u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .chop_en(chop_en), .offset(offset), .gain(gain), .fmt_offset_bin(fmt_offset_bin),
      .out_valid(out_valid), .out_code(out_code)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          due;
      logic [15:0] code;
      string       req;
   } exp_t;

   exp_t    expq[$];
   int      cyc = 0;
   int      checks = 0;
   int      fails = 0;
   bit      running = 1'b0;
   bit      pend = 1'b0;
   longint  held = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic longint sx24(logic [23:0] v);
      return longint'($signed(v));
   endfunction

   function automatic logic [15:0] model_code(longint x, logic [23:0] o, logic [15:0] g, bit f);
      longint v;
      longint r;
      logic [15:0] c;
      v = (x - sx24(o)) * longint'(g);
      r = (v + 64'sd4194304) >>> 23;
      if (r > 32767)       c = 16'h7FFF;
      else if (r < -32768) c = 16'h8000;
      else                 c = r[15:0];
      if (f) c[15] = ~c[15];
      return c;
   endfunction

   // one clock of stimulus plus reference model update
   task automatic step(bit v, logic [23:0] d, bit ch, logic [23:0] o, logic [15:0] g, bit f, string req);
      exp_t e;
      longint x;
      @(negedge clk);
      in_valid = v; in_data = d; chop_en = ch; offset = o; gain = g; fmt_offset_bin = f;
      if (!ch) pend = 1'b0;
      if (v) begin
         if (ch && !pend) begin
            pend = 1'b1;
            held = sx24(d);
         end else begin
            x = ch ? ((held + sx24(d)) >>> 1) : sx24(d);
            pend = 1'b0;
            e.due = cyc + 3; e.code = model_code(x, o, g, f); e.req = req;
            expq.push_back(e);
         end
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, 16'h8000, 1'b0, "R2");
   endtask

   always @(negedge clk) begin
      if (running) begin
         if (expq.size() > 0 && expq[0].due == cyc) begin
            checks++;
            if (!out_valid || out_code !== expq[0].code) begin
               fails++;
               $display("FAIL %s: out_valid=%0b out_code=%h expected valid=1 code=%h",
                        expq[0].req, out_valid, out_code, expq[0].code);
            end
            void'(expq.pop_front());
         end else if (out_valid) begin
            checks++;
            fails++;
            $display("FAIL R2: out_valid=1 expected 0 at cycle %0d", cyc);
         end
      end
   end

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      logic [23:0] rd;
      logic [23:0] ro;
      logic [15:0] rg;
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (out_valid !== 1'b0 || out_code !== 16'h0000) begin
         fails++;
         $display("FAIL R1: valid=%0b code=%h expected valid=0 code=0000", out_valid, out_code);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_code !== 16'h0000) begin
         fails++;
         $display("FAIL R1: after release valid=%0b code=%h expected 0/0000", out_valid, out_code);
      end
      running = 1'b1;

      // R5: unity gain passthrough, explicit value 0x123456 -> 0x1234
      step(1'b1, 24'h123456, 1'b0, 24'h0, 16'h8000, 1'b0, "R5");
      idle(2);
      @(negedge clk);
      checks++;
      if (out_code !== 16'h1234) begin
         fails++;
         $display("FAIL R5: code=%h expected 1234", out_code);
      end
      // R6: rounding at the half point, back-to-back (R2)
      step(1'b1, 24'h000080, 1'b0, 24'h0, 16'h8000, 1'b0, "R6");
      step(1'b1, 24'h00007F, 1'b0, 24'h0, 16'h8000, 1'b0, "R6");
      step(1'b1, 24'hFFFF80, 1'b0, 24'h0, 16'h8000, 1'b0, "R6");
      step(1'b1, 24'hFFFF7F, 1'b0, 24'h0, 16'h8000, 1'b0, "R6");
      step(1'b1, 24'h0001FF, 1'b0, 24'h0, 16'h8000, 1'b0, "R6");
      idle(4);
      // R4: offset applied before gain
      step(1'b1, 24'h010000, 1'b0, 24'h008000, 16'h4000, 1'b0, "R4");
      step(1'b1, 24'h000000, 1'b0, 24'hFF0000, 16'hC000, 1'b0, "R4");
      step(1'b1, 24'h400000, 1'b0, 24'h400000, 16'hFFFF, 1'b0, "R4");
      idle(4);
      // R7: saturation both sides, R8: offset binary
      step(1'b1, 24'h7FFFFF, 1'b0, 24'h0, 16'hFFFF, 1'b0, "R7");
      step(1'b1, 24'h7FFFFF, 1'b0, 24'h800000, 16'h8000, 1'b0, "R7");
      step(1'b1, 24'h800000, 1'b0, 24'h7FFFFF, 16'h8000, 1'b0, "R7");
      step(1'b1, 24'h800000, 1'b0, 24'h7FFFFF, 16'h8000, 1'b1, "R8");
      step(1'b1, 24'h7FFFFF, 1'b0, 24'h0, 16'hFFFF, 1'b1, "R8");
      step(1'b1, 24'h000000, 1'b0, 24'h0, 16'h8000, 1'b1, "R8");
      step(1'b1, 24'hFFFF00, 1'b0, 24'h0, 16'h8000, 1'b1, "R8");
      idle(4);
      // R3: chop pairs, back-to-back and gapped, restart mid-pair
      step(1'b1, 24'h100000, 1'b1, 24'h0, 16'h8000, 1'b0, "R3");
      step(1'b1, 24'h200001, 1'b1, 24'h0, 16'h8000, 1'b0, "R3");
      step(1'b1, 24'hF00001, 1'b1, 24'h000100, 16'h8000, 1'b0, "R3");
      step(1'b0, 24'h0, 1'b1, 24'h0, 16'h8000, 1'b0, "R3");
      step(1'b1, 24'hF00000, 1'b1, 24'h000100, 16'h9000, 1'b0, "R3");
      step(1'b1, 24'h300000, 1'b1, 24'h0, 16'h8000, 1'b0, "R3");
      step(1'b0, 24'h0, 1'b0, 24'h0, 16'h8000, 1'b0, "R3");
      step(1'b1, 24'h050000, 1'b1, 24'h0, 16'h8000, 1'b0, "R3");
      step(1'b1, 24'h070000, 1'b1, 24'h0, 16'h8000, 1'b0, "R3");
      idle(4);
      // R9: coefficients change every cycle while samples are in flight
      for (int i = 0; i < 8; i++)
         step(1'b1, 24'h200000 + 24'(i * 24'h011111), 1'b0, 24'(i * 24'h001000),
              16'h6000 + 16'(i * 16'h0800), i[0], "R9");
      idle(4);
      // mixed pseudo-random traffic covering R2..R8
      for (int i = 0; i < 400; i++) begin
         rd = 24'($urandom);
         ro = 24'($signed(12'($urandom)));
         rg = 16'($urandom);
         step(($urandom % 4) != 0, rd, (i / 100) % 2 == 1, ro, rg, ($urandom % 2) == 1, "R2");
      end
      idle(6);
      checks++;
      if (expq.size() != 0) begin
         fails++;
         $display("FAIL R2: %0d outputs missing, expected 0", expq.size());
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule